// File: doc/BRIEF.md
# Concurrent Write and Ones-Only Verify Controller

This controller sequences one 64-bit write into a row of resistive memory cells in which programming a 1 is far less reliable than programming a 0. A request carries the new word and, when known, the word already stored. The controller precharges the per-column sense stage once. It then drives the write current on every column and, during the same cycles, enables sensing only on the columns that go from 0 to 1. Each such column returns a done line that rises once its cell has flipped.

The write current is removed from every column as soon as all monitored columns have reported. Columns being cleared to 0 are not checked, because once the 1-writes have settled their error rate is negligible. When no column needs monitoring, a programmable minimum pulse is applied instead. A programmable limit stops a write that never finishes and reports the columns that did not switch.

Top module: `ones_verify_write`

## Requirements
- R1: The monitor mask is `req_data & ~req_old` when `req_old_known` is 1, and `req_data` when it is 0. It is presented on `verify_en` in every write cycle and is all zero in every other cycle.
- R2: After a request is accepted in idle, `precharge` is high for exactly max(`cfg_pre_cycles`,1) consecutive cycles starting the next cycle. Precharge occurs once per write and never in a cycle where `wr_drive` or `sense_en` is high.
- R3: `wr_drive` and `sense_en` rise together in the cycle after the last precharge cycle, and they fall together. `wr_data` equals the accepted `req_data` throughout the write.
- R4: Column done lines are sticky once seen. With a non-empty mask, the write lasts D+1 cycles, where D is the write-cycle index (from 0) in which the last monitored column is first seen high. `done` is high in the following cycle.
- R5: A `col_done` bit whose mask bit is 0 has no effect. Any `col_done` value during precharge has no effect.
- R6: With an empty mask, the write lasts exactly max(`cfg_min_pulse`,1) cycles and never times out.
- R7: With a non-empty mask, if not all monitored columns have been seen by write-cycle index max(`cfg_max_cycles`,1)-1, the write stops after that cycle. `timeout` is then 1 and `fail_cols` holds the monitored columns never seen done.
- R8: `done` is a one-cycle pulse followed by idle (`busy` low). `timeout` and `fail_cols` keep their values until the next request is accepted. `req_valid` while busy is ignored.
- R9: After reset, `busy`, `precharge`, `wr_drive`, `sense_en`, `done`, `timeout`, `verify_en` and `fail_cols` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a write (taken only when idle) |
| req_data | input | 64 | New word |
| req_old | input | 64 | Word currently stored |
| req_old_known | input | 1 | 1 when req_old is valid |
| cfg_pre_cycles | input | 16 | Precharge length in cycles (0 acts as 1) |
| cfg_min_pulse | input | 16 | Write length when nothing is monitored (0 acts as 1) |
| cfg_max_cycles | input | 16 | Write cycle limit (0 acts as 1) |
| col_done | input | 64 | Per-column sense outputs, high once switched |
| busy | output | 1 | A write is in progress |
| precharge | output | 1 | Sense precharge |
| sense_en | output | 1 | Sense amplifier enable |
| wr_drive | output | 1 | Write current on |
| wr_data | output | 64 | Word driven to the write drivers |
| verify_en | output | 64 | Per-column verify enable |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last write hit the cycle limit |
| fail_cols | output | 64 | Monitored columns that did not switch |

## Verification
Precharge starts the cycle after `req_valid` is sampled and lasts max(pre,1) cycles. The write follows at once. `done` appears one cycle after the write cycle in which the last monitored column is high, or one cycle after the limit or minimum-pulse cycle. The bench samples every output at the falling edge. It sets each column's done line for the next cycle from its own count of write cycles seen so far, and compares the measured precharge and write lengths, the mask and the failure vector with values computed from the per-column delays. `timeout` and `fail_cols` are checked again one cycle later, in idle.

// File: rtl/owv_pkg.sv
`timescale 1ns/1ps
package owv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } owv_state_t;
endpackage

// File: rtl/owv_timer.sv
`timescale 1ns/1ps
module owv_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] pre_len,
  input  logic [CNT_W-1:0] min_len,
  input  logic [CNT_W-1:0] max_len,
  output logic             pre_end,
  output logic             pulse_end,
  output logic             limit_end
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // a length of zero is treated as one cycle
  function automatic logic [CNT_W-1:0] last_idx(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : (len - CNT_ONE);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear)        cnt_q <= '0;
    else if (cnt_q != '1)  cnt_q <= cnt_q + CNT_ONE;
  end

  assign pre_end   = (cnt_q == last_idx(pre_len));
  assign pulse_end = (cnt_q == last_idx(min_len));
  assign limit_end = (cnt_q == last_idx(max_len));

  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/owv_mask.sv
`timescale 1ns/1ps
module owv_mask #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] req_data,
  input  logic [W-1:0] req_old,
  input  logic         req_old_known,
  input  logic         sensing,
  input  logic         capture_fail,
  input  logic [W-1:0] col_done,
  output logic [W-1:0] mask,
  output logic [W-1:0] data,
  output logic         mask_empty,
  output logic         all_done,
  output logic [W-1:0] fail_cols
);
  logic [W-1:0] mask_q, data_q, seen_q, fail_q, seen_now;

  // columns that rise from 0 to 1; all ones are watched when the old word is unknown
  function automatic logic [W-1:0] rising_cols(input logic [W-1:0] nw,
                                               input logic [W-1:0] od,
                                               input logic known);
    return known ? (nw & ~od) : nw;
  endfunction

  assign seen_now = seen_q | (col_done & mask_q & {W{sensing}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      data_q <= '0;
      seen_q <= '0;
      fail_q <= '0;
    end else if (accept) begin
      mask_q <= rising_cols(req_data, req_old, req_old_known);
      data_q <= req_data;
      seen_q <= '0;
      fail_q <= '0;
    end else begin
      if (sensing)      seen_q <= seen_now;
      if (capture_fail) fail_q <= mask_q & ~seen_now;
    end
  end

  assign mask       = mask_q;
  assign data       = data_q;
  assign mask_empty = (mask_q == '0);
  assign all_done   = &(seen_now | ~mask_q);
  assign fail_cols  = fail_q;

  // R7
  fail_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q & ~mask_q) == '0);
  // R5
  seen_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q & ~mask_q) == '0);
  // R4
  seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sensing && !accept) |=> ((seen_q & $past(seen_q)) == $past(seen_q)));
endmodule

// File: rtl/owv_fsm.sv
`timescale 1ns/1ps
module owv_fsm
  import owv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic pre_end,
  input  logic pulse_end,
  input  logic limit_end,
  input  logic mask_empty,
  input  logic all_done,
  output logic accept,
  output logic timer_clear,
  output logic st_pre,
  output logic st_write,
  output logic st_done,
  output logic st_busy,
  output logic limit_hit,
  output logic timeout
);
  owv_state_t state_q, state_d;
  logic       timeout_q, finish;

  assign finish    = mask_empty ? pulse_end : all_done;
  assign limit_hit = (state_q == ST_WRITE) && !mask_empty && !all_done && limit_end;
  assign accept    = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_PRE;
      ST_PRE:   if (pre_end)   state_d = ST_WRITE;
      ST_WRITE: if (finish || limit_hit) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign timer_clear = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      timeout_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept)         timeout_q <= 1'b0;
      else if (limit_hit) timeout_q <= 1'b1;
    end
  end

  assign st_pre   = (state_q == ST_PRE);
  assign st_write = (state_q == ST_WRITE);
  assign st_done  = (state_q == ST_DONE);
  assign st_busy  = (state_q != ST_IDLE);
  assign timeout  = timeout_q;

  // R3
  pre_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_pre |=> (st_pre || st_write));
  // R4
  write_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_write) |-> st_done);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> !st_busy);
  // R7
  timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> st_done);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && !st_done) |=> st_busy);
endmodule

// File: rtl/ones_verify_write.sv
`timescale 1ns/1ps
module ones_verify_write #(
  parameter int W     = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [W-1:0]     req_data,
  input  logic [W-1:0]     req_old,
  input  logic             req_old_known,
  input  logic [CNT_W-1:0] cfg_pre_cycles,
  input  logic [CNT_W-1:0] cfg_min_pulse,
  input  logic [CNT_W-1:0] cfg_max_cycles,
  input  logic [W-1:0]     col_done,
  output logic             busy,
  output logic             precharge,
  output logic             sense_en,
  output logic             wr_drive,
  output logic [W-1:0]     wr_data,
  output logic [W-1:0]     verify_en,
  output logic             done,
  output logic             timeout,
  output logic [W-1:0]     fail_cols
);
  logic accept, timer_clear, st_pre, st_write, st_done, st_busy, limit_hit;
  logic pre_end, pulse_end, limit_end, mask_empty, all_done;
  logic [W-1:0] mask, data_q;

  owv_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(timer_clear),
    .pre_len(cfg_pre_cycles), .min_len(cfg_min_pulse), .max_len(cfg_max_cycles),
    .pre_end(pre_end), .pulse_end(pulse_end), .limit_end(limit_end)
  );

  owv_mask #(.W(W)) u_mask (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .req_data(req_data), .req_old(req_old), .req_old_known(req_old_known),
    .sensing(st_write), .capture_fail(limit_hit), .col_done(col_done),
    .mask(mask), .data(data_q), .mask_empty(mask_empty),
    .all_done(all_done), .fail_cols(fail_cols)
  );

  owv_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .pre_end(pre_end), .pulse_end(pulse_end), .limit_end(limit_end),
    .mask_empty(mask_empty), .all_done(all_done),
    .accept(accept), .timer_clear(timer_clear),
    .st_pre(st_pre), .st_write(st_write), .st_done(st_done),
    .st_busy(st_busy), .limit_hit(limit_hit), .timeout(timeout)
  );

  assign busy      = st_busy;
  assign precharge = st_pre;
  assign wr_drive  = st_write;
  assign sense_en  = st_write;
  assign wr_data   = data_q;
  assign verify_en = mask & {W{st_write}};
  assign done      = st_done;

  // R2
  pre_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(precharge && (wr_drive || sense_en)));
  // R1
  verify_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_drive |-> (verify_en == '0));
  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> $stable(fail_cols));
endmodule

// File: tb/sim_ones_verify_write.sv
`timescale 1ns/1ps
module sim_ones_verify_write;
  localparam int W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [W-1:0] req_data = '0, req_old = '0, col_done = '0;
  logic req_old_known = 1'b0;
  logic [15:0] cfg_pre_cycles = 16'd1, cfg_min_pulse = 16'd1, cfg_max_cycles = 16'd1;
  logic busy, precharge, sense_en, wr_drive, done, timeout;
  logic [W-1:0] wr_data, verify_en, fail_cols;

  int n_checks = 0;
  int n_fail = 0;
  int dly [W];

  always #4 clk = ~clk;

  ones_verify_write u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .req_old(req_old), .req_old_known(req_old_known),
    .cfg_pre_cycles(cfg_pre_cycles), .cfg_min_pulse(cfg_min_pulse),
    .cfg_max_cycles(cfg_max_cycles), .col_done(col_done),
    .busy(busy), .precharge(precharge), .sense_en(sense_en), .wr_drive(wr_drive),
    .wr_data(wr_data), .verify_en(verify_en), .done(done), .timeout(timeout),
    .fail_cols(fail_cols)
  );

  function automatic logic [W-1:0] watch_set(logic [W-1:0] nw, logic [W-1:0] od, logic known);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = nw[i] && !(known && od[i]);
    return r;
  endfunction

  function automatic int floor1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one complete write; cols not in the watch set and precharge cycles get noise
  task automatic run_write(logic [W-1:0] nw, logic [W-1:0] od, logic known,
                           int pre, int minp, int maxc, bit poke_busy, string tag);
    logic [W-1:0] m, exp_fail, model;
    int p_len, w_len, exp_w, dmax, pc, wc, guard, bad_ver, bad_seq;
    bit exp_to, got_done, got_to;
    logic [W-1:0] got_fail;
    m = watch_set(nw, od, known);
    p_len = floor1(pre);
    dmax = -1;
    for (int i = 0; i < W; i++) if (m[i] && dly[i] > dmax) dmax = dly[i];
    exp_fail = '0;
    exp_to = 1'b0;
    if (m == '0) exp_w = floor1(minp);
    else if (dmax <= floor1(maxc) - 1) exp_w = dmax + 1;
    else begin
      exp_w = floor1(maxc);
      exp_to = 1'b1;
      for (int i = 0; i < W; i++) exp_fail[i] = m[i] && (dly[i] > exp_w - 1);
    end
    cfg_pre_cycles = 16'(pre);
    cfg_min_pulse  = 16'(minp);
    cfg_max_cycles = 16'(maxc);
    req_data = nw; req_old = od; req_old_known = known;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = poke_busy;
    if (poke_busy) begin req_data = ~nw; req_old = '0; req_old_known = 1'b0; end
    pc = 0; wc = 0; bad_ver = 0; bad_seq = 0; got_done = 0; got_to = 0; got_fail = '0;
    for (guard = 0; guard < 5000 && !got_done; guard++) begin
      if (precharge) begin
        pc++;
        if (wr_drive || sense_en || wc != 0) bad_seq++;
        col_done = rnd64();
      end else if (wr_drive) begin
        if (!sense_en || pc != p_len) bad_seq++;
        if (verify_en !== m || wr_data !== nw) bad_ver++;
        for (int i = 0; i < W; i++) model[i] = (dly[i] <= wc);
        col_done = (model & m) | (rnd64() & ~m);
        wc++;
      end else if (done) begin
        got_done = 1; got_to = timeout; got_fail = fail_cols;
        req_valid = 1'b0;
        col_done = '0;
      end else begin
        bad_seq++;
      end
      if (!got_done) @(negedge clk);
    end
    chk(got_done, {tag, " R8 done seen"}, W'(got_done), W'(1));
    chk(pc == p_len, {tag, " R2 precharge length"}, W'(pc), W'(p_len));
    chk(bad_seq == 0, {tag, " R3 phase order"}, W'(bad_seq), '0);
    chk(bad_ver == 0, {tag, " R1 verify mask/data"}, W'(bad_ver), '0);
    chk(wc == exp_w, {tag, " R4 write length"}, W'(wc), W'(exp_w));
    chk(got_to == exp_to, {tag, " R7 timeout"}, W'(got_to), W'(exp_to));
    chk(got_fail === exp_fail, {tag, " R7 failed columns"}, got_fail, exp_fail);
    @(negedge clk);
    chk(!busy && !done && verify_en == '0, {tag, " R8 back to idle"}, W'({busy, done}), '0);
    chk(timeout == exp_to && fail_cols === exp_fail, {tag, " R8 status held"}, fail_cols, exp_fail);
  endtask

  task automatic set_delays(int lo, int hi);
    for (int i = 0; i < W; i++) dly[i] = lo + int'($urandom % (hi - lo + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1957));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({busy, precharge, wr_drive, sense_en, done, timeout} == 6'b0 &&
        verify_en == '0 && fail_cols == '0, "R9 reset outputs", W'({busy, precharge, wr_drive}), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 known old word: only 0->1 columns monitored
    set_delays(0, 6);
    run_write(64'hF0F0_0000_FFFF_1234, 64'hFF00_FFFF_0F0F_0000, 1'b1, 3, 4, 30, 0, "known-old");
    // R1 unknown old word: every 1 is monitored
    set_delays(0, 6);
    run_write(64'h0000_00FF_8000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2, 4, 30, 0, "unknown-old");
    // R6 empty mask: all bits already set
    run_write(64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2, 7, 3, 0, "empty-mask");
    // R6 zero minimum and zero precharge act as one cycle
    run_write('0, '0, 1'b1, 0, 0, 5, 0, "zero-cfg");
    // R5 unmonitored columns and precharge noise ignored, slow watched column
    set_delays(0, 2);
    dly[40] = 9;
    run_write(64'h0000_0100_0000_0000, '0, 1'b1, 4, 1, 20, 0, "ignore R5");
    // R7 timeout with one slow column
    set_delays(0, 3);
    dly[7] = 50;
    run_write(64'h0000_0000_0000_0081, '0, 1'b1, 1, 1, 12, 0, "timeout");
    // R7 all columns watched, limit 0 acts as 1
    set_delays(0, 3);
    dly[0] = 0;
    run_write('1, '0, 1'b1, 1, 1, 0, 0, "all-ones-limit1");
    // R8 request raised while busy is ignored
    set_delays(0, 5);
    run_write(64'h00FF_00FF_00FF_00FF, '0, 1'b1, 2, 2, 40, 1, "busy-req R8");

    for (int t = 0; t < 40; t++) begin
      set_delays(0, 24);
      run_write(rnd64(), rnd64(), 1'($urandom), int'($urandom % 5),
                int'($urandom % 6), 10 + int'($urandom % 25), 0, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule